// File: doc/BRIEF.md
# Sequential-Load Outer Bank Register

This block sits between an inner bank-switching mapper and the cartridge memory of a multi-game cartridge. It takes the inner mapper's program and character bank numbers and narrows and relocates them, so that each game on the cartridge sees only its own window of the larger memory. The inner mapper is outside this block.

Software sets the block up by writing to the CPU window 0x6000–0x7FFF. Every write there goes to one of four 8-bit slots. A small state machine selects the slot and steps through them in a fixed ring. The slots are:
- slot 0: character base.
- slot 1: program base.
- slot 2: character size and a high character bit.
- slot 3: program mask and lock.

Setting the lock bit freezes the configuration until reset.

The state machine has five states. `ST_SLOT0`, `ST_SLOT1`, `ST_SLOT2` and `ST_SLOT3` name the slot that the next write fills. `ST_FROZEN` accepts no writes. Its transitions are:
- "advance": SLOT0→SLOT1→SLOT2→SLOT3, taken on an accepted write.
- "wrap": SLOT3→SLOT0, taken on a slot-3 write whose bit 6 is clear.
- "lock": SLOT3→FROZEN, taken on a slot-3 write whose bit 6 is set.
- "hold": each state stays where it is when no write is accepted, and FROZEN always stays.
- "reset": any state→SLOT0.

Top module: `outer_bank_seq`

## Requirements
- R1: A write is accepted only when `cpu_we` is high and `cpu_addr[15:13]` is 3'b011 (0x6000–0x7FFF). Any other write changes no slot and does not move the slot pointer.
- R2: Accepted writes fill slot 0, 1, 2, 3, then slot 0 again, and so on, each write storing `cpu_data` whole.
- R3: A write into slot 3 with data bit 6 set enters the frozen state. After that, every write is ignored and no slot or output changes.
- R4: `prg_bank` = (`inner_prg` AND (NOT slot3[5:0], zero-extended to 8 bits)) OR slot1. Bits 7:6 of `inner_prg` therefore never reach the output.
- R5: When slot2 bit 3 is 1, the character path keeps the low (slot2[2:0]+1) bits of `inner_chr` and clears the rest.
- R6: When slot2 bit 3 is 0, `inner_chr` contributes nothing to `chr_bank`.
- R7: `chr_bank[7:0]` is the masked `inner_chr` OR slot0, and `chr_bank[8]` equals slot2 bit 4.
- R8: Reset (`rst_n` low) clears all four slots, returns the pointer to slot 0 and leaves the frozen state. After reset, with any `inner_prg`, `prg_bank` is `inner_prg & 8'h3F` and `chr_bank` is 0.
- R9: The outputs follow `inner_prg` and `inner_chr` combinationally in the same cycle. A new slot value shows on the outputs from the clock edge that stores it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU write address |
| cpu_data | input | 8 | CPU write data |
| cpu_we | input | 1 | CPU write strobe, one cycle per write |
| inner_prg | input | 8 | Program bank number from the inner mapper |
| inner_chr | input | 8 | Character bank number from the inner mapper |
| prg_bank | output | 8 | Final program bank number |
| chr_bank | output | 9 | Final character bank number |

## Verification
The bench runs a full sweep of all 256 inner bank values for each of the eight character window sizes, for the window-disabled case, and for a range of program masks. A wrong mask width or an off-by-one in the power-of-two size would leak or drop inner bits at exactly one size.

It checks that the pointer wraps by letting a fifth write land in slot 0. A pointer that saturated, or reset to the wrong slot, would instead corrupt the program or size slot.

It checks the lock both ways. Writes after the lock must leave every output unchanged, and a reset must reopen slot 0. A design that kept advancing while frozen, or kept the lock through reset, fails one of those two checks. Writes just outside the window, at 0x5FFF and 0x8000, must do nothing.

// File: rtl/obr_pkg.sv
package obr_pkg;
    localparam int ADDR_W     = 16;
    localparam int DATA_W     = 8;
    localparam int NUM_SLOTS  = 4;
    localparam int PTR_W      = $clog2(NUM_SLOTS);
    localparam int PRG_W      = 8;
    localparam int CHR_IN_W   = 8;
    localparam int CHR_OUT_W  = CHR_IN_W + 1;
    localparam int PMASK_W    = 6;
    localparam int CSIZE_W    = 3;
    localparam logic [2:0] WIN_TAG = 3'b011;

    // slot field positions used by the mapping logic
    localparam int LOCK_BIT   = 6;
    localparam int CWIN_EN    = 3;
    localparam int CHI_BIT    = 4;

    typedef enum logic [2:0] {
        ST_SLOT0  = 3'd0,
        ST_SLOT1  = 3'd1,
        ST_SLOT2  = 3'd2,
        ST_SLOT3  = 3'd3,
        ST_FROZEN = 3'd4
    } obr_state_e;
endpackage

// File: rtl/obr_seq.sv
module obr_seq
    import obr_pkg::*;
(
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_hit,
    input  logic [DATA_W-1:0]                   wr_data,
    output obr_state_e                          cur_state,
    output logic [NUM_SLOTS-1:0][DATA_W-1:0]    bank_q
);
    obr_state_e              nxt_state;
    logic [NUM_SLOTS-1:0]    slot_we;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) cur_state <= ST_SLOT0;
        else        cur_state <= nxt_state;
    end

    // next-state logic
    always_comb begin
        nxt_state = cur_state;
        unique case (cur_state)
            ST_SLOT0:  if (wr_hit) nxt_state = ST_SLOT1;
            ST_SLOT1:  if (wr_hit) nxt_state = ST_SLOT2;
            ST_SLOT2:  if (wr_hit) nxt_state = ST_SLOT3;
            ST_SLOT3:  if (wr_hit) nxt_state = wr_data[LOCK_BIT] ? ST_FROZEN : ST_SLOT0;
            ST_FROZEN: nxt_state = ST_FROZEN;
            default:   nxt_state = ST_SLOT0;
        endcase
    end

    // output decode: slot write enables
    always_comb begin
        slot_we = '0;
        unique case (cur_state)
            ST_SLOT0:  slot_we[0] = wr_hit;
            ST_SLOT1:  slot_we[1] = wr_hit;
            ST_SLOT2:  slot_we[2] = wr_hit;
            ST_SLOT3:  slot_we[3] = wr_hit;
            ST_FROZEN: slot_we    = '0;
            default:   slot_we    = '0;
        endcase
    end

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)          bank_q[s] <= '0;
            else if (slot_we[s]) bank_q[s] <= wr_data;
        end
    end
endmodule

// File: rtl/obr_prg_map.sv
module obr_prg_map
    import obr_pkg::*;
(
    input  logic [PRG_W-1:0]  inner_prg,
    input  logic [DATA_W-1:0] prg_base,
    input  logic [DATA_W-1:0] prg_ctl,
    output logic [PRG_W-1:0]  prg_bank
);
    logic [PRG_W-1:0] keep;

    always_comb begin
        keep = '0;
        keep[PMASK_W-1:0] = ~prg_ctl[PMASK_W-1:0];
        prg_bank = (inner_prg & keep) | prg_base[PRG_W-1:0];
    end
endmodule

// File: rtl/obr_chr_map.sv
module obr_chr_map
    import obr_pkg::*;
(
    input  logic [CHR_IN_W-1:0]  inner_chr,
    input  logic [DATA_W-1:0]    chr_base,
    input  logic [DATA_W-1:0]    chr_ctl,
    output logic [CHR_OUT_W-1:0] chr_bank
);
    localparam int SH_W = CSIZE_W + 1;

    logic [SH_W-1:0]      width_m1;
    logic [CHR_OUT_W-1:0] win_mask;
    logic [CHR_OUT_W-1:0] inner_ext;

    always_comb begin
        width_m1  = {1'b0, chr_ctl[CSIZE_W-1:0]} + SH_W'(1);
        win_mask  = chr_ctl[CWIN_EN]
                  ? ((CHR_OUT_W'(1) << width_m1) - CHR_OUT_W'(1))
                  : '0;
        inner_ext = {1'b0, inner_chr};
        chr_bank  = (inner_ext & win_mask)
                  | {1'b0, chr_base[CHR_IN_W-1:0]}
                  | {chr_ctl[CHI_BIT], {CHR_IN_W{1'b0}}};
    end
endmodule

// File: rtl/outer_bank_seq.sv
module outer_bank_seq
    import obr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [15:0]          cpu_addr,
    input  logic [7:0]           cpu_data,
    input  logic                 cpu_we,
    input  logic [7:0]           inner_prg,
    input  logic [7:0]           inner_chr,
    output logic [7:0]           prg_bank,
    output logic [8:0]           chr_bank
);
    logic                              wr_hit;
    obr_state_e                        cur_state;
    logic [NUM_SLOTS-1:0][DATA_W-1:0]  bank_q;

    assign wr_hit = cpu_we && (cpu_addr[ADDR_W-1:ADDR_W-3] == WIN_TAG);

    obr_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_hit    (wr_hit),
        .wr_data   (cpu_data),
        .cur_state (cur_state),
        .bank_q    (bank_q)
    );

    obr_prg_map u_prg (
        .inner_prg (inner_prg),
        .prg_base  (bank_q[1]),
        .prg_ctl   (bank_q[3]),
        .prg_bank  (prg_bank)
    );

    obr_chr_map u_chr (
        .inner_chr (inner_chr),
        .chr_base  (bank_q[0]),
        .chr_ctl   (bank_q[2]),
        .chr_bank  (chr_bank)
    );
endmodule

// File: rtl/obr_check.sv
module obr_check
    import obr_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_hit,
    input  logic [7:0]                        wr_data,
    input  obr_state_e                        cur_state,
    input  logic [NUM_SLOTS-1:0][DATA_W-1:0]  bank_q,
    input  logic [7:0]                        prg_bank,
    input  logic [8:0]                        chr_bank
);
    // R1: no accepted write, nothing moves
    p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> ($stable(bank_q) && $stable(cur_state)));

    // R2: first slot takes the data, pointer advances
    p_slot0_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == ST_SLOT0 && wr_hit) |=> (bank_q[0] == $past(wr_data) && cur_state == ST_SLOT1));

    // R2: ring wraps from the last slot
    p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == ST_SLOT3 && wr_hit && !wr_data[6]) |=> cur_state == ST_SLOT0);

    // R3: lock entry and stickiness
    p_lock_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == ST_SLOT3 && wr_hit && wr_data[6]) |=> cur_state == ST_FROZEN);

    p_frozen_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == ST_FROZEN) |=> (cur_state == ST_FROZEN && $stable(bank_q)));

    // R4: program base bits always present on the output
    p_prg_base_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (prg_bank & bank_q[1]) == bank_q[1]);

    // R6: window off leaves only the base
    p_chr_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !bank_q[2][3] |-> chr_bank == {bank_q[2][4], bank_q[0]});

    // R7: high character bit
    p_chr_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
        chr_bank[8] == bank_q[2][4]);
endmodule

bind outer_bank_seq obr_check u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_hit    (wr_hit),
    .wr_data   (cpu_data),
    .cur_state (cur_state),
    .bank_q    (bank_q),
    .prg_bank  (prg_bank),
    .chr_bank  (chr_bank)
);

// File: tb/outer_bank_seq_tb.sv
module outer_bank_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_data = '0;
    logic        cpu_we = 1'b0;
    logic [7:0]  inner_prg = '0;
    logic [7:0]  inner_chr = '0;
    logic [7:0]  prg_bank;
    logic [8:0]  chr_bank;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    // bench model of the configuration
    logic [7:0] m_slot [4];
    int         m_ptr;
    bit         m_frozen;

    always #5 clk = ~clk;

    outer_bank_seq u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .cpu_we(cpu_we), .inner_prg(inner_prg), .inner_chr(inner_chr),
        .prg_bank(prg_bank), .chr_bank(chr_bank)
    );

    function automatic logic [7:0] exp_prg(input logic [7:0] ip);
        logic [7:0] keep;
        keep = ~m_slot[3] & 8'h3F;
        return (ip & keep) | m_slot[1];
    endfunction

    function automatic logic [8:0] exp_chr(input logic [7:0] ic);
        int w;
        int msk;
        int v;
        w   = int'(m_slot[2] & 8'h07) + 1;
        msk = (m_slot[2][3]) ? ((1 << w) - 1) : 0;
        v   = (int'(ic) & msk) | int'(m_slot[0]) | (m_slot[2][4] ? 256 : 0);
        return v[8:0];
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 4; i++) m_slot[i] = 8'h00;
        m_ptr = 0;
        m_frozen = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_data = d; cpu_we = 1'b1;
        @(negedge clk);
        cpu_we = 1'b0;
        if (a[15:13] == 3'b011 && !m_frozen) begin
            m_slot[m_ptr] = d;
            if (m_ptr == 3 && d[6]) m_frozen = 1'b1;
            else m_ptr = (m_ptr + 1) % 4;
        end
    endtask

    task automatic check_out(input string req, input logic [7:0] ip, input logic [7:0] ic);
        inner_prg = ip; inner_chr = ic;
        #1;
        n_checks++;
        if (prg_bank !== exp_prg(ip) || chr_bank !== exp_chr(ic)) begin
            n_errors++;
            $display("FAIL %s: prg=%h chr=%h expected prg=%h chr=%h (inner %h/%h)",
                     req, prg_bank, chr_bank, exp_prg(ip), exp_chr(ic), ip, ic);
        end
    endtask

    task automatic sweep(input string req);
        for (int v = 0; v < 256; v++) check_out(req, 8'(v), 8'(255 - v));
    endtask

    task automatic load4(input logic [7:0] a, input logic [7:0] b,
                         input logic [7:0] c, input logic [7:0] d);
        cpu_write(16'h6000, a);
        cpu_write(16'h6A01, b);
        cpu_write(16'h7123, c);
        cpu_write(16'h7FFF, d);
    endtask

    initial begin
        model_reset();
        do_reset();
        // R8: reset state
        check_out("R8", 8'hFF, 8'hFF);
        check_out("R8", 8'hC5, 8'h3C);

        // R1: writes outside the window are ignored
        cpu_write(16'h5FFF, 8'hAA);
        cpu_write(16'h8000, 8'h55);
        check_out("R1", 8'h00, 8'hFF);
        // R1: strobe low does nothing
        @(negedge clk);
        cpu_addr = 16'h6000; cpu_data = 8'h99; cpu_we = 1'b0;
        @(negedge clk);
        check_out("R1", 8'h00, 8'h00);
        // R1/R9: in-window write lands in slot 0, visible next cycle
        cpu_write(16'h6000, 8'h21);
        check_out("R9", 8'h00, 8'h00);

        // R2: fill the rest, then wrap into slot 0
        cpu_write(16'h6000, 8'h40);
        cpu_write(16'h6000, 8'h00);
        cpu_write(16'h6000, 8'h0F);
        check_out("R2", 8'hFF, 8'hFF);
        cpu_write(16'h6000, 8'h13);
        check_out("R2", 8'hFF, 8'hFF);
        cpu_write(16'h6000, 8'h80);   // slot 1 again
        check_out("R2", 8'h3F, 8'h00);

        // R5/R7/R4: every character window size, sweep of inner values
        for (int k = 0; k < 8; k++) begin
            do_reset();
            load4(8'h00, 8'(k << 5), 8'(8'h08 | k | ((k & 1) << 4)), 8'(8'h3F >> k));
            sweep("R5");
        end
        // R6: window disabled with base and high bit
        do_reset();
        load4(8'hA5, 8'h30, 8'h17, 8'h00);
        sweep("R6");
        // R4: full program mask and zero mask
        do_reset();
        load4(8'h00, 8'hC0, 8'h0F, 8'h3F);
        sweep("R4");

        // R3: lock then attempts to rewrite
        do_reset();
        load4(8'h12, 8'h04, 8'h1A, 8'h43);
        check_out("R3", 8'h77, 8'h77);
        cpu_write(16'h6000, 8'hFF);
        cpu_write(16'h6000, 8'hEE);
        cpu_write(16'h7000, 8'hDD);
        cpu_write(16'h6000, 8'h00);
        check_out("R3", 8'h77, 8'h77);
        check_out("R3", 8'hFF, 8'hFF);

        // R8: reset unlocks, slot 0 writable again
        do_reset();
        check_out("R8", 8'hFF, 8'hFF);
        cpu_write(16'h6000, 8'h5A);
        check_out("R8", 8'h00, 8'hFF);

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
        end
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule